// File: doc/BRIEF.md
# Copy Descriptor Ring Builder

This block turns one memory-copy request (a source address, a destination address and a byte count) into descriptor entries for a pair of circular descriptor rings used by a copy engine. The source side of the copy is described on a transmit ring whose descriptors each hold up to two buffers. The destination side is described on a receive ring whose descriptors each hold one buffer. Long requests are cut into chunks of at most `MAX_CHUNK` bytes.

The request arrives over a valid/ready handshake. The block then writes descriptor words, one per cycle, through a plain write port into descriptor storage held outside the block. When every word of the request has been written, the block publishes the new transmit CPU index on a one-cycle write strobe. One cycle later it pulses `done` and is ready again. After reset the block first sweeps the transmit ring and marks every descriptor as completed, so the engine sees an idle ring.

Top module: `copy_ring_builder`

## Requirements
- R1: After reset the block writes word 1 of every transmit slot, from 0 up to `RING_DEPTH-1`, with 0xC000_0000 (bit 31 done, bit 30 last-in-buffer-0). It does this before it asserts `req_ready` for the first time.
- R2: A request accepted with `req_len` equal to zero produces no descriptor write, no index publish and no `done`, and `req_ready` stays high.
- R3: The request is split into ceil(len / `MAX_CHUNK`) chunks. Every chunk except the last is `MAX_CHUNK` bytes, and the last carries the remainder. Chunk addresses advance by the sizes of the chunks before them.
- R4: Even-numbered chunks (0, 2, …) fill buffer 0 of a transmit descriptor. The chunk address goes in word 0 and the chunk length in flag bits [29:16].
- R5: Odd-numbered chunks fill buffer 1 of the same descriptor. The chunk address goes in word 2 and the chunk length in flag bits [13:0].
- R6: Each transmit descriptor's flag word (word 1) is written once, after its address words. Bits 31 and 15 are zero. Bit 30 is set only on the final descriptor when the chunk count is odd, and bit 14 only on the final descriptor when the chunk count is even. Bits [13:0] are zero when buffer 1 is unused.
- R7: The transmit write index starts at 0 after reset and advances by one, modulo `RING_DEPTH`, for each transmit descriptor. The published index (`idx_data` while `idx_wr` is high) is the slot after the last descriptor filled.
- R8: Receive descriptors are filled in slots `rx_cpu_idx`+1, +2, … modulo `RING_DEPTH`, with `rx_cpu_idx` sampled when the request is accepted. Each holds one chunk: its destination address in word 0, and its length in bits [29:16] of word 1 with all other bits zero.
- R9: `idx_wr` rises only after every descriptor word of the request has been written. `done` pulses for exactly the cycle after `idx_wr`. `req_ready` is low from acceptance through that `done` cycle. The write port encodes `mem_ring` 0 for transmit and 1 for receive, and `mem_word` as the word number 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_src | input | AW | Source byte address |
| req_dst | input | AW | Destination byte address |
| req_len | input | LEN_W | Copy length in bytes |
| rx_cpu_idx | input | IW | Current receive CPU index |
| mem_we | output | 1 | Descriptor word write strobe |
| mem_ring | output | 1 | 0 = transmit ring, 1 = receive ring |
| mem_slot | output | IW | Descriptor slot in the ring |
| mem_word | output | 2 | Word within the descriptor (0, 1, 2) |
| mem_wdata | output | 32 | Descriptor word value |
| idx_wr | output | 1 | Transmit CPU index publish strobe |
| idx_data | output | IW | New transmit CPU index |
| done | output | 1 | One-cycle request completion pulse |

## Verification
The bench uses the default parameters: an 8-slot ring, chunks of 0x3F80 bytes and a 20-bit length. This makes requests of up to seven chunks possible, with lengths at the exact chunk boundary, one byte over it, and remainders. The transmit write index wraps past slot 7 over the course of the run. The receive start slot wraps from a CPU index of 7. A scoreboard predicts the exact order of descriptor writes and publishes, so any field moved to another bit, word or slot is reported, and so is a publish issued too early.

// File: rtl/copy_ring_builder.sv
module copy_ring_builder #(
  parameter int AW         = 32,
  parameter int LEN_W      = 20,
  parameter int RING_DEPTH = 8,
  parameter int MAX_CHUNK  = 16256,
  localparam int IW        = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_src,
  input  logic [AW-1:0]    req_dst,
  input  logic [LEN_W-1:0] req_len,
  input  logic [IW-1:0]    rx_cpu_idx,
  output logic             mem_we,
  output logic             mem_ring,
  output logic [IW-1:0]    mem_slot,
  output logic [1:0]       mem_word,
  output logic [31:0]      mem_wdata,
  output logic             idx_wr,
  output logic [IW-1:0]    idx_data,
  output logic             done
);
  localparam int PLEN_W = 14;
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_CHUNK);
  localparam logic [IW-1:0] LAST_SLOT = IW'(RING_DEPTH - 1);

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_TA0, S_TA1, S_TFL, S_RA, S_RFL, S_PUB, S_FIN
  } st_t;

  st_t               st;
  logic [IW-1:0]     init_cnt, tx_wp, rx_wp;
  logic [AW-1:0]     src_cur, dst_cur;
  logic [LEN_W-1:0]  rem, len_sv;
  logic [PLEN_W-1:0] len0, len1;
  logic              last0, last1;

  logic [PLEN_W-1:0] chunk;
  logic              is_last;

  assign is_last   = (rem <= MAXL);
  assign chunk     = is_last ? rem[PLEN_W-1:0] : PLEN_W'(MAX_CHUNK);
  assign req_ready = (st == S_IDLE);
  assign idx_wr    = (st == S_PUB);
  assign idx_data  = tx_wp;
  assign done      = (st == S_FIN);

  always_comb begin
    mem_we    = 1'b0;
    mem_ring  = 1'b0;
    mem_slot  = tx_wp;
    mem_word  = 2'd0;
    mem_wdata = 32'h0;
    case (st)
      S_INIT: begin
        mem_we    = 1'b1;
        mem_slot  = init_cnt;
        mem_word  = 2'd1;
        mem_wdata = 32'hC000_0000;
      end
      S_TA0: begin
        mem_we    = 1'b1;
        mem_wdata = 32'(src_cur);
      end
      S_TA1: begin
        mem_we    = 1'b1;
        mem_word  = 2'd2;
        mem_wdata = 32'(src_cur);
      end
      S_TFL: begin
        mem_we    = 1'b1;
        mem_word  = 2'd1;
        mem_wdata = {1'b0, last0, len0, 1'b0, last1, len1};
      end
      S_RA: begin
        mem_we    = 1'b1;
        mem_ring  = 1'b1;
        mem_slot  = rx_wp;
        mem_wdata = 32'(dst_cur);
      end
      S_RFL: begin
        mem_we    = 1'b1;
        mem_ring  = 1'b1;
        mem_slot  = rx_wp;
        mem_word  = 2'd1;
        mem_wdata = {2'b00, len0, 16'h0000};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_INIT;
      init_cnt <= '0;
      tx_wp    <= '0;
      rx_wp    <= '0;
      src_cur  <= '0;
      dst_cur  <= '0;
      rem      <= '0;
      len_sv   <= '0;
      len0     <= '0;
      len1     <= '0;
      last0    <= 1'b0;
      last1    <= 1'b0;
    end else begin
      case (st)
        S_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == LAST_SLOT) st <= S_IDLE;
        end
        S_IDLE: begin
          if (req_valid && (req_len != '0)) begin
            src_cur <= req_src;
            dst_cur <= req_dst;
            rem     <= req_len;
            len_sv  <= req_len;
            rx_wp   <= rx_cpu_idx + 1'b1;
            st      <= S_TA0;
          end
        end
        S_TA0: begin
          len0    <= chunk;
          last0   <= is_last;
          len1    <= '0;
          last1   <= 1'b0;
          src_cur <= src_cur + AW'(chunk);
          rem     <= rem - LEN_W'(chunk);
          st      <= is_last ? S_TFL : S_TA1;
        end
        S_TA1: begin
          len1    <= chunk;
          last1   <= is_last;
          src_cur <= src_cur + AW'(chunk);
          rem     <= rem - LEN_W'(chunk);
          st      <= S_TFL;
        end
        S_TFL: begin
          tx_wp <= tx_wp + 1'b1;
          if (last0 || last1) begin
            rem <= len_sv;
            st  <= S_RA;
          end else begin
            st  <= S_TA0;
          end
        end
        S_RA: begin
          len0    <= chunk;
          last0   <= is_last;
          dst_cur <= dst_cur + AW'(chunk);
          rem     <= rem - LEN_W'(chunk);
          st      <= S_RFL;
        end
        S_RFL: begin
          rx_wp <= rx_wp + 1'b1;
          st    <= last0 ? S_PUB : S_RA;
        end
        S_PUB:   st <= S_FIN;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module copy_ring_builder_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_src,
  input logic [LEN_W-1:0] req_len,
  input logic             mem_we,
  input logic             mem_ring,
  input logic [1:0]       mem_word,
  input logic [31:0]      mem_wdata,
  input logic             idx_wr,
  input logic             done
);
  a_r9_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready);

  a_r9_done_follows_publish: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (done && !idx_wr));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_no_write_after_publish: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> !mem_we);

  a_r2_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (req_ready && !mem_we && !idx_wr));

  a_r8_rx_word_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ring) |-> (mem_word != 2'd2));

  a_r8_rx_flag_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ring && mem_word == 2'd1) |-> (mem_wdata[31:30] == 2'b00 && mem_wdata[15:0] == 16'h0));

  a_r4_first_addr_is_src: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && req_len != '0)) |-> (mem_we && !mem_ring && mem_word == 2'd0 && mem_wdata == 32'($past(req_src))));
endmodule

bind copy_ring_builder copy_ring_builder_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_len(req_len), .mem_we(mem_we), .mem_ring(mem_ring),
  .mem_word(mem_word), .mem_wdata(mem_wdata), .idx_wr(idx_wr), .done(done)
);

// File: tb/test_copy_ring_builder.sv
module test_copy_ring_builder;
  localparam int MAXC = 16256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_src = '0, req_dst = '0;
  logic [19:0] req_len = '0;
  logic [2:0]  rx_cpu_idx = '0;
  logic        mem_we, mem_ring, idx_wr, done;
  logic [2:0]  mem_slot, idx_data;
  logic [1:0]  mem_word;
  logic [31:0] mem_wdata;

  always #5 clk = ~clk;

  copy_ring_builder i_copy_ring_builder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .rx_cpu_idx(rx_cpu_idx),
    .mem_we(mem_we), .mem_ring(mem_ring), .mem_slot(mem_slot), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .idx_wr(idx_wr), .idx_data(idx_data), .done(done)
  );

  // item: {kind[38:37] 0 tx / 1 rx / 2 publish, slot[36:34], word[33:32], data[31:0]}
  logic [38:0] exp_q[$];
  int vectors = 0, fails = 0, wr_seen = 0;
  logic [2:0] tp = '0;
  logic prev_idx_wr = 1'b0;

  function automatic string tag_of(logic [38:0] it);
    if (it[38:37] == 2'd2) return "R7";
    if (it[38:37] == 2'd1) return "R8";
    if (it[33:32] == 2'd0) return "R4";
    if (it[33:32] == 2'd2) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [38:0] act, logic [38:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we || idx_wr) begin
        logic [38:0] got, want;
        if (mem_we) begin
          got = {1'b0, mem_ring, mem_slot, mem_word, mem_wdata};
          wr_seen++;
        end else got = {2'd2, idx_data, 2'd0, 32'h0};
        if (exp_q.size() == 0) check("R9 unexpected", got, '0);
        else begin
          want = exp_q.pop_front();
          check(tag_of(want), got, want);
        end
      end
      if (prev_idx_wr) check("R9 done", {38'h0, done}, 39'd1);
      prev_idx_wr = idx_wr;
    end
  end

  // R3: chunking model; R4/R5/R6 transmit packing; R8 receive; R7 publish
  task automatic run_req(logic [31:0] s, logic [31:0] d, int len, logic [2:0] rxi);
    int rem = len, i = 0, c, l0 = 0;
    logic [31:0] a = s;
    logic [2:0] r = rxi + 3'd1;
    while (rem > 0) begin
      c = (rem > MAXC) ? MAXC : rem;
      rem -= c;
      if (i % 2 == 0) begin
        exp_q.push_back({2'd0, tp, 2'd0, a});
        l0 = c;
        if (rem == 0) begin
          exp_q.push_back({2'd0, tp, 2'd1, 32'h4000_0000 | (32'(l0) << 16)});
          tp++;
        end
      end else begin
        exp_q.push_back({2'd0, tp, 2'd2, a});
        exp_q.push_back({2'd0, tp, 2'd1, (32'(l0) << 16) | 32'(c) | ((rem == 0) ? 32'h4000 : 32'h0)});
        tp++;
      end
      a += c;
      i++;
    end
    rem = len;
    a = d;
    while (rem > 0) begin
      c = (rem > MAXC) ? MAXC : rem;
      rem -= c;
      exp_q.push_back({2'd1, r, 2'd0, a});
      exp_q.push_back({2'd1, r, 2'd1, 32'(c) << 16});
      a += c;
      r++;
    end
    exp_q.push_back({2'd2, tp, 2'd0, 32'h0});
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_src = s; req_dst = d; req_len = 20'(len); rx_cpu_idx = rxi;
    @(negedge clk);
    req_valid = 1'b0; rx_cpu_idx = 3'd0;
    check("R9 ready low while building", {38'h0, req_ready}, 39'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R9 ready after done", {38'h0, req_ready}, 39'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int w0;
    for (int k = 0; k < 8; k++) exp_q.push_back({2'd0, 3'(k), 2'd1, 32'hC000_0000});
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready low during init", {38'h0, req_ready}, 39'd0);
    while (!req_ready) @(negedge clk);
    check("R1 init sweep complete", 39'(exp_q.size()), 39'd0);
    check("R7 reset index", {36'h0, idx_data}, 39'd0);

    // R2: zero length ignored
    w0 = wr_seen;
    req_valid = 1'b1; req_len = '0; req_src = 32'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 ready stays", {38'h0, req_ready}, 39'd1);
    check("R2 no writes", 39'(wr_seen - w0), 39'd0);
    check("R2 no done", {38'h0, done}, 39'd0);

    run_req(32'h1000_0000, 32'h2000_0000, 1, 3'd7);
    run_req(32'h1000_0100, 32'h2000_0400, MAXC, 3'd0);
    run_req(32'h3000_0000, 32'h4000_0000, MAXC + 1, 3'd2);
    run_req(32'h0000_1000, 32'h0008_0000, 3 * MAXC, 3'd4);
    run_req(32'h0010_0004, 32'h0020_0008, 3 * MAXC + 500, 3'd6);
    run_req(32'h5000_0000, 32'h6000_0000, 7 * MAXC - 3, 3'd5);
    run_req(32'hABCD_0000, 32'h1111_0000, 2 * MAXC, 3'd7);

    repeat (3) @(negedge clk);
    check("R3 all expected items produced", 39'(exp_q.size()), 39'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule